// File: doc/BRIEF.md
# Inter-Processor Interrupt Routing Engine

This block turns one 64-bit software request for an inter-processor interrupt into a series of delivery pulses, one for each processor context that qualifies. With the request come a request kind (group-0, group-1 or alias group-1), the requester's security state and the requester's own affinity. The block settles the interrupt group once, when it accepts the request. It then steps through every context in ascending index order, one context per clock. A context's affinity is read from a small table that a write port loads.

There are two routing modes. In broadcast mode every context receives the interrupt except the context whose affinity equals the requester's. In targeted mode a context qualifies only when all three of these hold:

- its upper three affinity levels match the request;
- its lowest affinity byte lies in the 16-wide window chosen by the range selector;
- the matching bit of the 16-bit target bitmap is set.

While a scan runs, the block raises `busy` and ignores new requests. A single `done` pulse closes each scan.

Top module: `sgi_route_engine`

## Requirements
- R1: Request fields are taken from `req_data` as follows. Bits 55:48, 39:32 and 23:16 are the upper, middle and lower cluster affinity. Bits 27:24 are the interrupt ID. Bit 40 is the broadcast flag. Bits 47:44 are the range selector. Bits 15:0 are the target bitmap. Every delivery carries the interrupt ID on `dlv_intid`.
- R2: Kind code 1 (group-1) resolves to group code 2 (group-1 non-secure) when `req_ns`=1, and to code 1 (group-1 secure) when `req_ns`=0.
- R3: Kind code 2 (alias group-1) inverts that choice: code 1 when `req_ns`=1, and code 2 when `req_ns`=0.
- R4: Kind code 0, and the unused kind code 3, always resolve to group code 0 (group-0 secure).
- R5: When `cfg_single_sec`=1, a resolved group code 1 is replaced by code 0. Group code 1 never appears on `dlv_group` while this bit is set.
- R6: When the broadcast flag is 1, every context whose table affinity differs from `req_self_aff` receives the interrupt, and the context whose affinity is equal does not.
- R7: When the broadcast flag is 0, a context can qualify only if its table affinity bits 31:8 equal {upper, middle, lower} from the request.
- R8: When the broadcast flag is 0, the context's lowest affinity byte A0 must also satisfy RS*16 <= A0 <= RS*16+15, and target bitmap bit (A0 - RS*16) must be 1.
- R9: `dlv_ns` on every delivery equals `req_ns` as sampled when the request was accepted.
- R10: Deliveries come in ascending context order, at most one per cycle. `dlv_ctx` gives the context index.
- R11: `busy` rises on the edge that accepts a request (`req_valid`=1 while `busy`=0). A `req_valid` seen while `busy`=1 is ignored and starts no second scan.
- R12: `done` pulses for one cycle on the (N_CTX+2)-th clock edge counted from the accepting edge. That is the edge that presents the last context's result. `busy` falls on the same edge.
- R13: Affinity table entry `aff_wr_idx` takes `aff_wr_data` (Aff3 in bits 31:24, down to Aff0 in bits 7:0) when `aff_wr_en`=1. Later scans use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_single_sec | input | 1 | Single security state configuration |
| aff_wr_en | input | 1 | Affinity table write enable |
| aff_wr_idx | input | IDX_W | Affinity table entry index |
| aff_wr_data | input | 32 | Affinity value to store |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 group-0, 1 group-1, 2 alias group-1 |
| req_ns | input | 1 | Requester is non-secure |
| req_self_aff | input | 32 | Requester's own affinity |
| req_data | input | 64 | Software write value |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished pulse |
| dlv_valid | output | 1 | Delivery pulse |
| dlv_ctx | output | IDX_W | Receiving context index |
| dlv_intid | output | 4 | Interrupt ID |
| dlv_group | output | 2 | 0 G0 secure, 1 G1 secure, 2 G1 non-secure |
| dlv_ns | output | 1 | Requester non-secure flag |

## Verification
The bench sweeps every combination of kind, security state and single-security setting. A design that mixed up the alias inversion or forgot the override would put the wrong code on `dlv_group`. It also drives targeted requests with bitmaps and range selectors that land on window edges (A0 = 0, 15, 16, 26) and on contexts that differ from the request in only one upper affinity level. A wrong window bound or bit offset would deliver to a neighbouring context or drop one. Broadcast is tried both with the requester present in the table and with it absent, and a request injected mid-scan checks that a busy engine neither restarts nor mixes fields from two requests.

// File: rtl/sgi_route_pkg.sv
package sgi_route_pkg;
  localparam int AFF_W   = 32;
  localparam int REQ_W   = 64;
  localparam int ID_W    = 4;
  localparam int TL_W    = 16;
  localparam int RS_W    = 4;

  typedef enum logic [1:0] {
    GRP0_SEC   = 2'd0,
    GRP1_SEC   = 2'd1,
    GRP1_NSEC  = 2'd2
  } grp_e;

  typedef enum logic [1:0] {
    KIND_G0  = 2'd0,
    KIND_G1  = 2'd1,
    KIND_AG1 = 2'd2
  } kind_e;

  typedef struct packed {
    logic [7:0]      up;
    logic [7:0]      mid;
    logic [7:0]      low;
    logic [TL_W-1:0] tlist;
    logic [ID_W-1:0] intid;
    logic            bcast;
    logic [RS_W-1:0] rsel;
    grp_e            grp;
  } req_t;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
  import sgi_route_pkg::*;
(
  input  logic [REQ_W-1:0] data,
  input  logic [1:0]       kind,
  input  logic             ns,
  input  logic             single_sec,
  output req_t             fields
);
  grp_e raw_grp;

  always_comb begin
    case (kind)
      KIND_G1:  raw_grp = ns ? GRP1_NSEC : GRP1_SEC;
      KIND_AG1: raw_grp = ns ? GRP1_SEC  : GRP1_NSEC;
      default:  raw_grp = GRP0_SEC;
    endcase
  end

  always_comb begin
    fields.up    = data[55:48];
    fields.mid   = data[39:32];
    fields.low   = data[23:16];
    fields.tlist = data[15:0];
    fields.intid = data[27:24];
    fields.bcast = data[40];
    fields.rsel  = data[47:44];
    fields.grp   = (single_sec && raw_grp == GRP1_SEC) ? GRP0_SEC : raw_grp;
  end
endmodule

// File: rtl/sgi_aff_table.sv
module sgi_aff_table #(
  parameter int N_CTX = 8,
  parameter int DW    = 32,
  localparam int IDX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] mem [N_CTX];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/sgi_target_match.sv
module sgi_target_match
  import sgi_route_pkg::*;
(
  input  logic [AFF_W-1:0] aff,
  input  logic [AFF_W-1:0] self_aff,
  input  req_t             fields,
  output logic             hit
);
  logic             cluster_eq;
  logic             window_eq;
  logic [RS_W-1:0]  bit_pos;
  logic             bit_set;

  always_comb begin
    cluster_eq = (aff[31:8] == {fields.up, fields.mid, fields.low});
    window_eq  = (aff[7:4] == fields.rsel);
    bit_pos    = aff[3:0];
    bit_set    = fields.tlist[bit_pos];
    if (fields.bcast) hit = (aff != self_aff);
    else              hit = cluster_eq && window_eq && bit_set;
  end
endmodule

// File: rtl/sgi_route_engine.sv
module sgi_route_engine
  import sgi_route_pkg::*;
#(
  parameter int N_CTX = 8,
  localparam int IDX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_single_sec,
  input  logic             aff_wr_en,
  input  logic [IDX_W-1:0] aff_wr_idx,
  input  logic [31:0]      aff_wr_data,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_ns,
  input  logic [31:0]      req_self_aff,
  input  logic [63:0]      req_data,
  output logic             busy,
  output logic             done,
  output logic             dlv_valid,
  output logic [IDX_W-1:0] dlv_ctx,
  output logic [3:0]       dlv_intid,
  output logic [1:0]       dlv_group,
  output logic             dlv_ns
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CTX - 1);

  req_t             dec;
  req_t             fld_q;
  logic [31:0]      self_q;
  logic             ns_q;
  logic             iss_vld;
  logic [IDX_W-1:0] iss_cnt;
  logic             rd_vld;
  logic [IDX_W-1:0] rd_ctx;
  logic [31:0]      rd_aff;
  logic             hit;
  logic             accept;

  assign accept = req_valid && !busy;

  sgi_req_decode u_dec (
    .data       (req_data),
    .kind       (req_kind),
    .ns         (req_ns),
    .single_sec (cfg_single_sec),
    .fields     (dec)
  );

  sgi_aff_table #(.N_CTX(N_CTX), .DW(32)) u_tab (
    .clk     (clk),
    .wr_en   (aff_wr_en),
    .wr_idx  (aff_wr_idx),
    .wr_data (aff_wr_data),
    .rd_idx  (iss_cnt),
    .rd_data (rd_aff)
  );

  sgi_target_match u_match (
    .aff      (rd_aff),
    .self_aff (self_q),
    .fields   (fld_q),
    .hit      (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      iss_vld   <= 1'b0;
      iss_cnt   <= '0;
      rd_vld    <= 1'b0;
      rd_ctx    <= '0;
      fld_q     <= '0;
      self_q    <= '0;
      ns_q      <= 1'b0;
      dlv_valid <= 1'b0;
      dlv_ctx   <= '0;
      dlv_intid <= '0;
      dlv_group <= '0;
      dlv_ns    <= 1'b0;
    end else begin
      done      <= 1'b0;
      dlv_valid <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        iss_vld <= 1'b1;
        iss_cnt <= '0;
        fld_q   <= dec;
        self_q  <= req_self_aff;
        ns_q    <= req_ns;
      end else if (iss_vld) begin
        if (iss_cnt == LAST) iss_vld <= 1'b0;
        else                 iss_cnt <= iss_cnt + 1'b1;
      end
      rd_vld <= iss_vld;
      rd_ctx <= iss_cnt;
      if (rd_vld) begin
        dlv_valid <= hit;
        dlv_ctx   <= rd_ctx;
        dlv_intid <= fld_q.intid;
        dlv_group <= fld_q.grp;
        dlv_ns    <= ns_q;
        if (rd_ctx == LAST) begin
          done <= 1'b1;
          busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sgi_route_checks.sv
module sgi_route_checks #(
  parameter int N_CTX = 8,
  localparam int IDX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic             dlv_valid,
  input logic [IDX_W-1:0] dlv_ctx,
  input logic [3:0]       dlv_intid,
  input logic [1:0]       dlv_group,
  input logic             dlv_ns
);
  p_done_ends_busy_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_busy_fall_done_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_busy_rise_req_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
  p_dlv_in_scan_r11: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> $past(busy));
  p_ascending_r10: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && $past(dlv_valid) && !$past(done)) |-> (dlv_ctx > $past(dlv_ctx)));
  p_fields_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && $past(dlv_valid) && !$past(done)) |->
      ($stable(dlv_ns) && $stable(dlv_intid) && $stable(dlv_group)));
  p_group_legal_r2: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (dlv_group != 2'd3));
endmodule

bind sgi_route_engine sgi_route_checks #(.N_CTX(N_CTX)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .dlv_valid (dlv_valid),
  .dlv_ctx   (dlv_ctx),
  .dlv_intid (dlv_intid),
  .dlv_group (dlv_group),
  .dlv_ns    (dlv_ns)
);

// File: tb/sgi_route_engine_tb_top.sv
module sgi_route_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_single_sec;
  logic          aff_wr_en;
  logic [IW-1:0] aff_wr_idx;
  logic [31:0]   aff_wr_data;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic          req_ns;
  logic [31:0]   req_self_aff;
  logic [63:0]   req_data;
  logic          busy, done, dlv_valid, dlv_ns;
  logic [IW-1:0] dlv_ctx;
  logic [3:0]    dlv_intid;
  logic [1:0]    dlv_group;

  int checks = 0;
  int errors = 0;
  logic [31:0] aff_tb [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  sgi_route_engine #(.N_CTX(N)) dut_i (
    .clk(clk), .rst(rst), .cfg_single_sec(cfg_single_sec),
    .aff_wr_en(aff_wr_en), .aff_wr_idx(aff_wr_idx), .aff_wr_data(aff_wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_ns(req_ns),
    .req_self_aff(req_self_aff), .req_data(req_data),
    .busy(busy), .done(done), .dlv_valid(dlv_valid), .dlv_ctx(dlv_ctx),
    .dlv_intid(dlv_intid), .dlv_group(dlv_group), .dlv_ns(dlv_ns)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] a3, input logic [7:0] a2,
                                     input logic [7:0] a1, input logic [3:0] rs,
                                     input logic irm, input logic [3:0] id,
                                     input logic [15:0] tl);
    logic [63:0] d = '0;
    d[55:48] = a3; d[47:44] = rs; d[40] = irm; d[39:32] = a2;
    d[27:24] = id; d[23:16] = a1; d[15:0] = tl;
    return d;
  endfunction

  function automatic logic [1:0] exp_grp(input int kind, input bit ns, input bit ss);
    logic [1:0] g;
    if (kind == 1)      g = ns ? 2'd2 : 2'd1;
    else if (kind == 2) g = ns ? 2'd1 : 2'd2;
    else                g = 2'd0;
    if (ss && g == 2'd1) g = 2'd0;
    return g;
  endfunction

  function automatic logic [N-1:0] exp_mask(input logic [63:0] d, input logic [31:0] self_aff);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) begin
      int a0  = aff_tb[i][7:0];
      int lo  = d[47:44] * 16;
      if (d[40]) m[i] = (aff_tb[i] != self_aff);
      else if (aff_tb[i][31:24] == d[55:48] && aff_tb[i][23:16] == d[39:32] &&
               aff_tb[i][15:8] == d[23:16] && a0 >= lo && a0 <= lo + 15)
        m[i] = d[a0 - lo];
    end
    return m;
  endfunction

  task automatic wr_aff(input int idx, input logic [31:0] v);
    @(negedge clk);
    aff_wr_en = 1'b1; aff_wr_idx = IW'(idx); aff_wr_data = v;
    aff_tb[idx] = v;
    @(negedge clk);
    aff_wr_en = 1'b0;
  endtask

  task automatic run(input int kind, input bit ns, input bit ss, input logic [63:0] d,
                     input logic [31:0] self_aff, input bit inject, input string tag);
    logic [N-1:0] got = '0;
    logic [N-1:0] expm;
    bit fld_ok = 1'b1;
    bit ord_ok = 1'b1;
    int last = -1;
    int done_at = -1;
    logic [1:0] eg;
    expm = exp_mask(d, self_aff);
    eg = exp_grp(kind, ns, ss);
    @(negedge clk);
    cfg_single_sec = ss;
    req_valid = 1'b1; req_kind = 2'(kind); req_ns = ns; req_self_aff = self_aff; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= N + 4; c++) begin
      if (c == 1) check(busy == 1'b1, "R11 busy after accept", busy, 1);
      if (inject && c == 3) begin
        req_valid = 1'b1; req_kind = 2'd1; req_ns = ~ns; req_self_aff = 32'hFFFF_FFFF;
        req_data = mk(8'h00, 8'h00, 8'h00, 4'h0, 1'b1, ~d[27:24], 16'h0);
      end
      if (inject && c == 4) req_valid = 1'b0;
      if (dlv_valid) begin
        got[dlv_ctx] = 1'b1;
        if (int'(dlv_ctx) <= last) ord_ok = 1'b0;
        last = int'(dlv_ctx);
        if (dlv_intid != d[27:24] || dlv_group != eg || dlv_ns != ns) fld_ok = 1'b0;
      end
      if (done && done_at < 0) done_at = c;
      if (c < N + 4) @(negedge clk);
    end
    check(got == expm, {"R6/R7/R8 target mask ", tag}, got, expm);
    check(fld_ok, {"R1 R2 R3 R4 R5 R9 delivery fields ", tag}, dlv_group, eg);
    check(ord_ok, {"R10 ascending order ", tag}, last, N - 1);
    check(done_at == N + 2, {"R12 done timing ", tag}, done_at, N + 2);
    check(busy == 1'b0, {"R11 R12 idle after scan ", tag}, busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_single_sec = 1'b0; aff_wr_en = 1'b0; aff_wr_idx = '0; aff_wr_data = '0;
    req_valid = 1'b0; req_kind = '0; req_ns = 1'b0; req_self_aff = '0; req_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy == 0 && done == 0 && dlv_valid == 0, "R12 reset state", {busy, done, dlv_valid}, 0);

    // R13: load the table
    wr_aff(0, 32'h0102_0300);
    wr_aff(1, 32'h0102_0305);
    wr_aff(2, 32'h0102_030F);
    wr_aff(3, 32'h0102_0310);
    wr_aff(4, 32'h0102_031A);
    wr_aff(5, 32'h0102_0400);
    wr_aff(6, 32'h0103_0300);
    wr_aff(7, 32'h0202_0301);

    // R2 R3 R4 R5 sweep, broadcast excluding ctx 2 (R6)
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 2; n++)
        for (int s = 0; s < 2; s++)
          run(k, n[0], s[0], mk(8'h0, 8'h0, 8'h0, 4'h0, 1'b1, 4'(k * 4 + n * 2 + s), 16'h0),
              aff_tb[2], 1'b0, "grp sweep");

    // R6: requester not in table, all receive
    run(1, 1'b1, 1'b0, mk(8'h0, 8'h0, 8'h0, 4'h0, 1'b1, 4'h9, 16'h0), 32'h7777_7777, 1'b0, "bcast all");

    // R7 R8: targeted window and bitmap sweeps
    for (int rs = 0; rs < 3; rs++) begin
      run(0, 1'b0, 1'b0, mk(8'h01, 8'h02, 8'h03, 4'(rs), 1'b0, 4'h3, 16'hFFFF), 32'h0, 1'b0, "tgt full");
      run(1, 1'b1, 1'b0, mk(8'h01, 8'h02, 8'h03, 4'(rs), 1'b0, 4'h5, 16'h8021), 32'h0, 1'b0, "tgt edges");
      run(2, 1'b0, 1'b1, mk(8'h01, 8'h02, 8'h03, 4'(rs), 1'b0, 4'hA, 16'h0401), 32'h0, 1'b0, "tgt sparse");
    end
    run(1, 1'b0, 1'b0, mk(8'h01, 8'h02, 8'h04, 4'h0, 1'b0, 4'h1, 16'h0001), 32'h0, 1'b0, "tgt aff1");
    run(1, 1'b0, 1'b0, mk(8'h01, 8'h03, 8'h03, 4'h0, 1'b0, 4'h2, 16'h0001), 32'h0, 1'b0, "tgt aff2");
    run(1, 1'b0, 1'b0, mk(8'h02, 8'h02, 8'h03, 4'h0, 1'b0, 4'h4, 16'h0002), 32'h0, 1'b0, "tgt aff3");
    run(0, 1'b1, 1'b0, mk(8'h01, 8'h02, 8'h03, 4'h0, 1'b0, 4'h6, 16'h7FDF), 32'h0, 1'b0, "tgt holes");

    // R11: request during scan is ignored
    run(1, 1'b0, 1'b0, mk(8'h0, 8'h0, 8'h0, 4'h0, 1'b1, 4'hC, 16'h0), aff_tb[5], 1'b1, "inject");
    for (int c = 0; c < 4; c++) begin
      check(busy == 0 && dlv_valid == 0, "R11 no second scan", {busy, dlv_valid}, 0);
      @(negedge clk);
    end

    // R13: rewrite an entry and rescan
    wr_aff(3, 32'h0102_0301);
    run(1, 1'b1, 1'b0, mk(8'h01, 8'h02, 8'h03, 4'h0, 1'b0, 4'h7, 16'h0002), 32'h0, 1'b0, "R13 rewrite");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule